// File: doc/BRIEF.md
# Flash Erase-Suspend Control Register

This block is an 8-bit memory-mapped control register that lets software, or an interrupt, pause a running flash auto-erase and later resume it. Software reaches it through a plain register bus: address, write strobe, write data, and combinational read data. Status inputs report whether an erase is in progress, whether CPU rewrite mode is active, and whether the chip runs from the slow clock with the main oscillator stopped. From these it drives a suspend request to the erase engine, a suspended flag, and an enable for low-current flash reads.

Three of the control bits are guarded against stray writes. Such a bit takes a 1 only when a write of 0 to that bit is followed at once by a write of 1. The suspend-request bit has no such guard, but clearing it to resume the erase only works while rewrite mode is active. An enabled interrupt arriving during an erase can also set the suspend-request bit by hardware.

Bit layout: bit 0 is the suspend enable, bit 1 the suspend request, bit 2 the interrupt-suspend enable and bit 7 the low-current-read enable. Bits 3 to 6 are reserved.

Top module: `esus_ctl_reg`

## Requirements
- R1: After reset all register bits are 0, and suspend_req, suspended and low_cur_read are 0.
- R2: Bits 3 to 6 always read as 0, whatever is written. bus_rdata is 0 whenever bus_addr differs from the register address.
- R3: While bit 0 is 0, a software write of 1 to bit 1 is ignored and irq_pulse has no effect, so bit 1 stays 0.
- R4: While bit 0 is 1, a register write with bit 1 = 1 sets bit 1. suspended equals bit 0 AND bit 1, and suspend_req equals bit 0 AND bit 1 AND erase_busy.
- R5: When bits 0 and 2 are both 1, an irq_pulse in a cycle with erase_busy = 1 sets bit 1 at the next edge. With erase_busy = 0 the pulse has no effect.
- R6: Bits 0, 2 and 7 are guarded. Writing 0 to a guarded bit clears it. Writing 1 sets it only if the previous bus write went to this register with that bit at 0; otherwise the bit keeps its value.
- R7: Any bus write to another address between the 0-write and the 1-write disarms the guard, so the 1-write is then ignored.
- R8: A register write with bit 1 = 0 clears bit 1 only while rewrite_mode is 1; otherwise bit 1 keeps its value.
- R9: If an interrupt set of bit 1 and a software clear of bit 1 fall in the same cycle, bit 1 ends at 1.
- R10: low_cur_read equals bit 7 AND slow_clk_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| irq_pulse | input | 1 | Pulse marking an enabled interrupt request |
| erase_busy | input | 1 | An auto-erase is in progress |
| rewrite_mode | input | 1 | CPU rewrite mode is active |
| slow_clk_mode | input | 1 | Slow clock with main oscillator stopped |
| suspend_req | output | 1 | Suspend request to the erase engine |
| suspended | output | 1 | Suspend enabled and requested |
| low_cur_read | output | 1 | Low-current flash read enable |

## Verification
The interrupt-driven set of the suspend bit and a software write that clears it can land on the same clock edge. The bench provokes this by raising irq_pulse in the same cycle as a resume write, with rewrite mode active and an erase running, and then expects the bit read back as 1. A second contest, the guarded-bit unlock against an intervening write to another address, is covered by the sweep: its model re-evaluates the arming on every bus write and compares the read-back after each of several hundred writes.

// File: rtl/esus_pkg.sv
package esus_pkg;
  localparam int REG_W    = 8;
  localparam int POS_EN   = 0;
  localparam int POS_REQ  = 1;
  localparam int POS_IEN  = 2;
  localparam int POS_LOWC = 7;
  localparam int N_GUARD  = 3;
  // guarded-bit slot order: 0 = enable, 1 = irq enable, 2 = low-current
  localparam logic [REG_W-1:0] RSVD_MASK = 8'b0111_1000;
endpackage

// File: rtl/esus_unlock.sv
module esus_unlock #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic         hit,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] armed
);
  for (genvar i = 0; i < N; i++) begin : g_arm
    logic arm_q, arm_d, arm_en;

    always_comb begin
      arm_en = bus_we;
      arm_d  = hit & ~wbits[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      arm_q <= 1'b0;
      else if (arm_en) arm_q <= arm_d;
    end

    assign armed[i] = arm_q;
  end
endmodule

// File: rtl/esus_ctl_bits.sv
module esus_ctl_bits #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic [N-1:0] wguard,
  input  logic         wreq,
  input  logic [N-1:0] armed,
  input  logic         rewrite_mode,
  input  logic         irq_pulse,
  input  logic         erase_busy,
  output logic [N-1:0] guard_q,
  output logic         req_q
);
  // guarded bits
  for (genvar i = 0; i < N; i++) begin : g_guard
    logic g_q, g_d, g_en;

    always_comb begin
      g_en = hit & (~wguard[i] | armed[i]);
      g_d  = wguard[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    g_q <= 1'b0;
      else if (g_en) g_q <= g_d;
    end

    assign guard_q[i] = g_q;
  end

  // suspend request bit; slot 0 = enable, slot 1 = irq enable
  logic hw_set, sw_set, sw_clr, req_d, req_en, req_r;

  always_comb begin
    hw_set = guard_q[0] & guard_q[1] & irq_pulse & erase_busy;
    sw_set = hit & wreq & guard_q[0];
    sw_clr = hit & ~wreq & rewrite_mode;
    req_en = hw_set | sw_set | sw_clr;
    req_d  = hw_set | sw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_r <= 1'b0;
    else if (req_en) req_r <= req_d;
  end

  assign req_q = req_r;
endmodule

// File: rtl/esus_ctl_reg.sv
module esus_ctl_reg #(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              irq_pulse,
  input  logic              erase_busy,
  input  logic              rewrite_mode,
  input  logic              slow_clk_mode,
  output logic              suspend_req,
  output logic              suspended,
  output logic              low_cur_read
);
  import esus_pkg::*;

  logic                 sel, hit;
  logic [N_GUARD-1:0]   wguard, armed, guard_q;
  logic                 req_q;
  logic [REG_W-1:0]     ctl_q;
  logic                 unused_rsvd_wr;

  assign sel    = (bus_addr == REG_ADDR);
  assign hit    = bus_we & sel;
  assign wguard = {bus_wdata[POS_LOWC], bus_wdata[POS_IEN], bus_wdata[POS_EN]};
  assign unused_rsvd_wr = ^(bus_wdata & RSVD_MASK);

  esus_unlock #(.N(N_GUARD)) u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_we (bus_we),
    .hit    (hit),
    .wbits  (wguard),
    .armed  (armed)
  );

  esus_ctl_bits #(.N(N_GUARD)) u_bits (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit          (hit),
    .wguard       (wguard),
    .wreq         (bus_wdata[POS_REQ]),
    .armed        (armed),
    .rewrite_mode (rewrite_mode),
    .irq_pulse    (irq_pulse),
    .erase_busy   (erase_busy),
    .guard_q      (guard_q),
    .req_q        (req_q)
  );

  always_comb begin
    ctl_q           = '0;
    ctl_q[POS_EN]   = guard_q[0];
    ctl_q[POS_REQ]  = req_q;
    ctl_q[POS_IEN]  = guard_q[1];
    ctl_q[POS_LOWC] = guard_q[2];
  end

  assign bus_rdata    = sel ? ctl_q : '0;
  assign suspended    = ctl_q[POS_EN] & ctl_q[POS_REQ];
  assign suspend_req  = suspended & erase_busy;
  assign low_cur_read = ctl_q[POS_LOWC] & slow_clk_mode;
endmodule

// File: rtl/esus_ctl_chk.sv
module esus_ctl_chk #(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              irq_pulse,
  input logic              erase_busy,
  input logic              rewrite_mode,
  input logic              slow_clk_mode,
  input logic              suspend_req,
  input logic              low_cur_read,
  input logic [7:0]        ctl_q
);
  logic hit, prev_zero0;
  assign hit = bus_we && (bus_addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_zero0 <= 1'b0;
    else if (bus_we) prev_zero0 <= hit && !bus_wdata[0];
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[6:3] == 4'b0);

  a_r3_no_req_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] && !hit |=> !ctl_q[1] || $past(ctl_q[1]));

  a_r4_idle_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_busy |-> !suspend_req);

  a_r5_irq_sets_req: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0] && ctl_q[2] && irq_pulse && erase_busy |=> ctl_q[1]);

  a_r6_lone_one_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    hit && bus_wdata[0] && !prev_zero0 && !ctl_q[0] |=> !ctl_q[0]);

  a_r8_resume_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1] && !rewrite_mode |=> ctl_q[1]);

  a_r10_lowcur_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_clk_mode |-> !low_cur_read);
endmodule

bind esus_ctl_reg esus_ctl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_we        (bus_we),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .irq_pulse     (irq_pulse),
  .erase_busy    (erase_busy),
  .rewrite_mode  (rewrite_mode),
  .slow_clk_mode (slow_clk_mode),
  .suspend_req   (suspend_req),
  .low_cur_read  (low_cur_read),
  .ctl_q         (ctl_q)
);

// File: tb/esus_ctl_reg_test.sv
module esus_ctl_reg_test;
  localparam int PERIOD = 10;
  localparam logic [3:0] RA = 4'h6;
  localparam logic [3:0] OA = 4'h2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq_pulse, erase_busy, rewrite_mode, slow_clk_mode;
  logic       suspend_req, suspended, low_cur_read;

  int n_run = 0;
  int n_fail = 0;

  // bench model state for the sweep
  logic [7:0] m_ctl;
  logic [2:0] m_arm;

  always #(PERIOD/2) clk = ~clk;

  esus_ctl_reg #(.ADDR_W(4), .REG_ADDR(RA)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse),
    .erase_busy(erase_busy), .rewrite_mode(rewrite_mode),
    .slow_clk_mode(slow_clk_mode), .suspend_req(suspend_req),
    .suspended(suspended), .low_cur_read(low_cur_read)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = RA; bus_wdata = '0;
    irq_pulse = 1'b0; erase_busy = 1'b0; rewrite_mode = 1'b0; slow_clk_mode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_ctl = '0; m_arm = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic irq);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; irq_pulse = irq;
    @(negedge clk);
    bus_we = 1'b0; irq_pulse = 1'b0; bus_addr = RA;
    #1;
  endtask

  task automatic pulse_irq();
    irq_pulse = 1'b1;
    @(negedge clk);
    irq_pulse = 1'b0;
    #1;
  endtask

  // requirement model of one bus write, no interrupt
  task automatic model_wr(input logic h, input logic [7:0] d, input logic rew);
    logic [7:0] nxt;
    logic [2:0] gb;
    int pos [3];
    pos = '{0, 2, 7};
    nxt = m_ctl;
    for (int k = 0; k < 3; k++) begin
      gb[k] = d[pos[k]];
      if (h && !gb[k]) nxt[pos[k]] = 1'b0;
      else if (h && m_arm[k]) nxt[pos[k]] = 1'b1;
    end
    if (h && d[1] && m_ctl[0]) nxt[1] = 1'b1;
    else if (h && !d[1] && rew) nxt[1] = 1'b0;
    for (int k = 0; k < 3; k++) m_arm[k] = h && !gb[k];
    m_ctl = nxt;
  endtask

  initial begin
    #(PERIOD*200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 outputs", {5'b0, suspend_req, suspended, low_cur_read}, 8'h00);

    // R6 lone write of 1 ignored
    wr(RA, 8'h85, 1'b0);
    chk("R6 lone one", bus_rdata, 8'h00);

    // R3 request ignored while bit 0 is 0
    erase_busy = 1'b1;
    wr(RA, 8'h02, 1'b0);
    chk("R3 sw req off", bus_rdata, 8'h00);
    wr(RA, 8'h00, 1'b0);
    wr(RA, 8'h04, 1'b0);
    chk("R6 irq enable unlock", bus_rdata, 8'h04);
    pulse_irq();
    chk("R3 irq off", bus_rdata, 8'h04);
    chk("R3 no suspend", {7'b0, suspend_req}, 8'h00);

    // R6 unlock enable
    wr(RA, 8'h04, 1'b0);
    wr(RA, 8'h05, 1'b0);
    chk("R6 enable unlock", bus_rdata, 8'h05);

    // R5 interrupt set, R4 outputs
    pulse_irq();
    chk("R5 irq set", bus_rdata, 8'h07);
    chk("R4 outputs busy", {6'b0, suspend_req, suspended}, 8'h03);

    // R8 resume gated
    rewrite_mode = 1'b0;
    wr(RA, 8'h05, 1'b0);
    chk("R8 resume blocked", bus_rdata, 8'h07);
    rewrite_mode = 1'b1;
    wr(RA, 8'h05, 1'b0);
    chk("R8 resume accepted", bus_rdata, 8'h05);

    // R5 no effect when idle
    erase_busy = 1'b0;
    pulse_irq();
    chk("R5 idle irq", bus_rdata, 8'h05);

    // R9 hardware set beats software clear
    erase_busy = 1'b1;
    wr(RA, 8'h07, 1'b0);
    wr(RA, 8'h05, 1'b1);
    chk("R9 contest", bus_rdata, 8'h07);

    // R4 suspend_req follows erase_busy
    erase_busy = 1'b0;
    #1;
    chk("R4 idle outputs", {6'b0, suspend_req, suspended}, 8'h01);

    // R7 intervening write disarms
    wr(RA, 8'h07, 1'b0);
    wr(OA, 8'h00, 1'b0);
    wr(RA, 8'h87, 1'b0);
    chk("R7 disarmed", bus_rdata, 8'h07);
    wr(RA, 8'h07, 1'b0);
    wr(RA, 8'h87, 1'b0);
    chk("R6 low-current unlock", bus_rdata, 8'h87);

    // R10 low-current gate
    slow_clk_mode = 1'b0; #1;
    chk("R10 gated off", {7'b0, low_cur_read}, 8'h00);
    slow_clk_mode = 1'b1; #1;
    chk("R10 active", {7'b0, low_cur_read}, 8'h01);

    // R2 reserved bits and other addresses
    wr(RA, 8'hFF, 1'b0);
    chk("R2 reserved", bus_rdata & 8'h78, 8'h00);
    bus_addr = OA; #1;
    chk("R2 other addr", bus_rdata, 8'h00);
    bus_addr = RA; #1;

    // sweep of all write values against the model (R6, R7, R8, R2)
    do_reset();
    for (int i = 0; i < 512; i++) begin
      logic [7:0] d;
      logic rew, other;
      d = i[7:0];
      rew = i[3] ^ i[8];
      other = (i % 13) == 12;
      rewrite_mode = rew;
      if (other) begin
        wr(OA, d, 1'b0);
        model_wr(1'b0, d, rew);
      end else begin
        wr(RA, d, 1'b0);
        model_wr(1'b1, d, rew);
      end
      chk("R6 R7 R8 sweep", bus_rdata, m_ctl);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule